// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a (process ID, virtual page number) pair into a physical frame number. It keeps one table with exactly one entry per physical frame; an entry's position is its frame number, and the entry records which process and virtual page currently occupy that frame. Because the table is indexed by frame and not by page, a lookup cannot index it directly. The key is hashed into a small anchor table. The selected anchor names the first candidate entry. Colliding keys are chained through a next-pointer held in each entry. The walk compares one entry per clock. It returns the frame number and the full physical address on a match, or a page fault when the chain ends or a visit budget runs out.

Requests and responses use valid/ready handshakes. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The block works on one lookup at a time, so `req_ready` stays low from acceptance until the response has been taken. A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the response is held unchanged. Mappings are added through an insert channel that also uses valid/ready. An insert completes in a single cycle and has priority over a lookup offered in the same cycle.

Top module: `ivt_lookup`

## Requirements
- R1: After reset, every entry and every anchor is invalid, `rsp_valid` is 0, `req_ready` and `ins_ready` are 1, and any lookup returns a page fault one cycle after acceptance.
- R2: The anchor index is the XOR of all HASH_W-bit slices of the virtual page number and all HASH_W-bit slices of the process ID. Slice 0 is the least significant bits, and the top slice is zero-padded. Bit j of the index is therefore the parity of the key bits whose position modulo HASH_W equals j.
- R3: An accepted insert writes the key into entry `ins_frame` in one cycle and places that entry at the head of its hash chain; its next-pointer takes the anchor's previous contents. `ins_ready` is 1 only while no lookup is in progress.
- R4: A hit returns the matching entry's index on `rsp_frame` and `{rsp_frame, req_off}` on `rsp_paddr`, with `rsp_hit`=1.
- R5: The walk examines one entry per clock. Measured in clock edges from the acceptance edge to the first cycle with `rsp_valid` high, the latency is 1 when the anchor is empty, k+2 for a hit at chain position k (0 = most recently inserted), and L+1 for a miss on a chain of L entries.
- R6: When no entry on the chain holds both the requested process ID and virtual page number, the response has `rsp_fault`=1 and `rsp_hit`=0.
- R7: A walk visits at most FRAMES entries and then ends with a fault, so a chain that loops back on itself returns a fault with latency FRAMES+1.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, every response output stays stable. `req_ready` stays 0 from acceptance until the response transfers.
- R9: Whenever `rsp_valid` is 1, exactly one of `rsp_hit` and `rsp_fault` is 1.
- R10: While `ins_valid` is 1, `req_ready` is 0, so an insert and a lookup offered together resolve insert first, and the lookup then sees the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_pid | input | PID_W | Requesting process ID |
| req_vpn | input | VPN_W | Virtual page number |
| req_off | input | OFF_W | Offset within the page |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Page fault: no mapping found |
| rsp_frame | output | FRAME_W | Matched frame number (0 on fault) |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address, frame over offset |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert accepted when high |
| ins_frame | input | FRAME_W | Frame whose entry is written |
| ins_pid | input | PID_W | Process ID to record |
| ins_vpn | input | VPN_W | Virtual page number to record |

## Verification
On every cycle, the assertions check the handshake rules. They confirm that a stalled response holds, that no request is accepted while one is in flight, that an insert blocks lookups, and that a response carries exactly one outcome. A cycle counter checks that no lookup takes longer than FRAMES+1 cycles. Only the bench's scenarios can show that the frame is correct, that the hash picks the right chain, that head insertion orders the chain, and the exact per-position latency. For these, it fills the table and then sweeps every key against an arithmetic model, and it forces a self-looping chain to exercise the visit bound.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_SCAN = 2'd1,
    WK_RESP = 2'd2
  } walk_state_e;
endpackage

// File: rtl/ivt_hash.sv
module ivt_hash #(
  parameter int PID_W  = 3,
  parameter int VPN_W  = 6,
  parameter int HASH_W = 2
) (
  input  logic [PID_W-1:0]  pid,
  input  logic [VPN_W-1:0]  vpn,
  output logic [HASH_W-1:0] slot
);
  localparam int NV = (VPN_W + HASH_W - 1) / HASH_W;
  localparam int NP = (PID_W + HASH_W - 1) / HASH_W;

  logic [NV*HASH_W-1:0] vpn_pad;
  logic [NP*HASH_W-1:0] pid_pad;

  assign vpn_pad = {{(NV*HASH_W-VPN_W){1'b0}}, vpn} ;
  assign pid_pad = {{(NP*HASH_W-PID_W){1'b0}}, pid} ;

  always_comb begin
    slot = '0;
    for (int i = 0; i < NV; i++) slot = slot ^ vpn_pad[i*HASH_W +: HASH_W];
    for (int i = 0; i < NP; i++) slot = slot ^ pid_pad[i*HASH_W +: HASH_W];
  end
endmodule

// File: rtl/ivt_store.sv
module ivt_store #(
  parameter int FRAMES = 8,
  parameter int PID_W  = 3,
  parameter int VPN_W  = 6,
  parameter int HASH_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(FRAMES)-1:0]  wr_frame,
  input  logic [HASH_W-1:0]          wr_slot,
  input  logic [PID_W-1:0]           wr_pid,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [HASH_W-1:0]          lk_slot,
  output logic                       lk_head_ok,
  output logic [$clog2(FRAMES)-1:0]  lk_head,
  input  logic [$clog2(FRAMES)-1:0]  rd_frame,
  output logic                       rd_ok,
  output logic [PID_W-1:0]           rd_pid,
  output logic [VPN_W-1:0]           rd_vpn,
  output logic                       rd_link_ok,
  output logic [$clog2(FRAMES)-1:0]  rd_link
);
  localparam int FW    = $clog2(FRAMES);
  localparam int SLOTS = 1 << HASH_W;

  logic [FRAMES-1:0]  ent_ok;
  logic [FRAMES-1:0]  ent_link_ok;
  logic [PID_W-1:0]   ent_pid  [FRAMES];
  logic [VPN_W-1:0]   ent_vpn  [FRAMES];
  logic [FW-1:0]      ent_link [FRAMES];
  logic [SLOTS-1:0]   anc_ok;
  logic [FW-1:0]      anc_head [SLOTS];

  // Valid bits carry reset; payload fields need none.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_ok      <= '0;
      ent_link_ok <= '0;
      anc_ok      <= '0;
    end else if (wr_en) begin
      ent_ok[wr_frame]      <= 1'b1;
      ent_link_ok[wr_frame] <= anc_ok[wr_slot];
      anc_ok[wr_slot]       <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_pid[wr_frame]  <= wr_pid;
      ent_vpn[wr_frame]  <= wr_vpn;
      ent_link[wr_frame] <= anc_head[wr_slot];
      anc_head[wr_slot]  <= wr_frame;
    end
  end

  assign lk_head_ok = anc_ok[lk_slot];
  assign lk_head    = anc_head[lk_slot];
  assign rd_ok      = ent_ok[rd_frame];
  assign rd_pid     = ent_pid[rd_frame];
  assign rd_vpn     = ent_vpn[rd_frame];
  assign rd_link_ok = ent_link_ok[rd_frame];
  assign rd_link    = ent_link[rd_frame];
endmodule

// File: rtl/ivt_walk.sv
module ivt_walk
  import ivt_pkg::*;
#(
  parameter int FRAMES = 8,
  parameter int PID_W  = 3,
  parameter int VPN_W  = 6,
  parameter int OFF_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [PID_W-1:0]           req_pid,
  input  logic [VPN_W-1:0]           req_vpn,
  input  logic [OFF_W-1:0]           req_off,
  input  logic                       ins_valid,
  output logic                       idle,
  input  logic                       head_ok,
  input  logic [$clog2(FRAMES)-1:0]  head,
  output logic [$clog2(FRAMES)-1:0]  cur,
  input  logic                       ent_ok,
  input  logic [PID_W-1:0]           ent_pid,
  input  logic [VPN_W-1:0]           ent_vpn,
  input  logic                       link_ok,
  input  logic [$clog2(FRAMES)-1:0]  link,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       rsp_hit,
  output logic [$clog2(FRAMES)-1:0]  rsp_frame,
  output logic [OFF_W-1:0]           rsp_off
);
  localparam int FW    = $clog2(FRAMES);
  localparam int CNT_W = $clog2(FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST_VISIT = CNT_W'(FRAMES - 1);

  walk_state_e        state;
  logic [PID_W-1:0]   key_pid;
  logic [VPN_W-1:0]   key_vpn;
  logic [CNT_W-1:0]   visits;
  logic               match;

  assign idle      = (state == WK_IDLE);
  assign req_ready = idle && !ins_valid;
  assign rsp_valid = (state == WK_RESP);
  assign match     = ent_ok && (ent_pid == key_pid) && (ent_vpn == key_vpn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= WK_IDLE;
      key_pid   <= '0;
      key_vpn   <= '0;
      rsp_off   <= '0;
      cur       <= '0;
      visits    <= '0;
      rsp_hit   <= 1'b0;
      rsp_frame <= '0;
    end else begin
      case (state)
        WK_IDLE: begin
          if (req_valid && req_ready) begin
            key_pid <= req_pid;
            key_vpn <= req_vpn;
            rsp_off <= req_off;
            visits  <= '0;
            if (head_ok) begin
              cur   <= head;
              state <= WK_SCAN;
            end else begin
              rsp_hit   <= 1'b0;
              rsp_frame <= '0;
              state     <= WK_RESP;
            end
          end
        end
        WK_SCAN: begin
          if (match) begin
            rsp_hit   <= 1'b1;
            rsp_frame <= cur;
            state     <= WK_RESP;
          end else if (!link_ok || visits == LAST_VISIT) begin
            rsp_hit   <= 1'b0;
            rsp_frame <= '0;
            state     <= WK_RESP;
          end else begin
            cur    <= link;
            visits <= visits + 1'b1;
          end
        end
        WK_RESP: begin
          if (rsp_ready) state <= WK_IDLE;
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  logic unused_fw;
  assign unused_fw = ^{FW{1'b0}};
endmodule

// File: rtl/ivt_lookup.sv
module ivt_lookup #(
  parameter int FRAMES = 8,
  parameter int PID_W  = 3,
  parameter int VPN_W  = 6,
  parameter int OFF_W  = 4,
  parameter int HASH_W = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [PID_W-1:0]                 req_pid,
  input  logic [VPN_W-1:0]                 req_vpn,
  input  logic [OFF_W-1:0]                 req_off,
  output logic                             rsp_valid,
  input  logic                             rsp_ready,
  output logic                             rsp_hit,
  output logic                             rsp_fault,
  output logic [$clog2(FRAMES)-1:0]        rsp_frame,
  output logic [$clog2(FRAMES)+OFF_W-1:0]  rsp_paddr,
  input  logic                             ins_valid,
  output logic                             ins_ready,
  input  logic [$clog2(FRAMES)-1:0]        ins_frame,
  input  logic [PID_W-1:0]                 ins_pid,
  input  logic [VPN_W-1:0]                 ins_vpn
);
  localparam int FW = $clog2(FRAMES);

  logic [HASH_W-1:0] req_slot, ins_slot;
  logic              idle, wr_en;
  logic              head_ok, ent_ok, link_ok, hit_q;
  logic [FW-1:0]     head, cur, link;
  logic [PID_W-1:0]  ent_pid;
  logic [VPN_W-1:0]  ent_vpn;
  logic [OFF_W-1:0]  off_q;

  ivt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .HASH_W(HASH_W)) u_hash_req (
    .pid(req_pid), .vpn(req_vpn), .slot(req_slot));

  ivt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .HASH_W(HASH_W)) u_hash_ins (
    .pid(ins_pid), .vpn(ins_vpn), .slot(ins_slot));

  assign ins_ready = idle;
  assign wr_en     = ins_valid && ins_ready;

  ivt_store #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .HASH_W(HASH_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_frame(ins_frame), .wr_slot(ins_slot),
    .wr_pid(ins_pid), .wr_vpn(ins_vpn),
    .lk_slot(req_slot), .lk_head_ok(head_ok), .lk_head(head),
    .rd_frame(cur), .rd_ok(ent_ok), .rd_pid(ent_pid), .rd_vpn(ent_vpn),
    .rd_link_ok(link_ok), .rd_link(link));

  ivt_walk #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_off(req_off),
    .ins_valid(ins_valid), .idle(idle),
    .head_ok(head_ok), .head(head), .cur(cur),
    .ent_ok(ent_ok), .ent_pid(ent_pid), .ent_vpn(ent_vpn),
    .link_ok(link_ok), .link(link),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(hit_q), .rsp_frame(rsp_frame), .rsp_off(off_q));

  assign rsp_hit   = rsp_valid && hit_q;
  assign rsp_fault = rsp_valid && !hit_q;
  assign rsp_paddr = {rsp_frame, off_q};
endmodule

module ivt_lookup_chk #(
  parameter int FRAMES = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic                       rsp_hit,
  input logic                       rsp_fault,
  input logic [$clog2(FRAMES)-1:0]  rsp_frame,
  input logic                       ins_valid
);
  localparam int CW = $clog2(FRAMES + 4);

  logic          busy;
  logic [CW-1:0] lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      lat  <= '0;
    end else if (req_valid && req_ready) begin
      busy <= 1'b1;
      lat  <= CW'(1);
    end else if (busy && rsp_valid && rsp_ready) begin
      busy <= 1'b0;
    end else if (busy && !rsp_valid) begin
      lat <= lat + 1'b1;
    end
  end

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_fault}) == 1);

  p_hold_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_frame)));

  p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_insert_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> !req_ready);

  p_visit_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lat <= CW'(FRAMES + 1));
endmodule

bind ivt_lookup ivt_lookup_chk #(.FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_fault(rsp_fault), .rsp_frame(rsp_frame), .ins_valid(ins_valid));

// File: tb/sim_ivt_lookup.sv
module sim_ivt_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int FRAMES = 8;
  localparam int PID_W  = 3;
  localparam int VPN_W  = 6;
  localparam int OFF_W  = 4;
  localparam int HASH_W = 2;
  localparam int FW     = $clog2(FRAMES);
  localparam int SLOTS  = 1 << HASH_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 1, ins_valid = 0;
  logic [PID_W-1:0] req_pid = 0, ins_pid = 0;
  logic [VPN_W-1:0] req_vpn = 0, ins_vpn = 0;
  logic [OFF_W-1:0] req_off = 0;
  logic [FW-1:0]    ins_frame = 0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault, ins_ready;
  logic [FW-1:0]       rsp_frame;
  logic [FW+OFF_W-1:0] rsp_paddr;

  int total = 0, bad = 0;

  // reference model
  logic          m_ok [FRAMES];
  logic          m_lok[FRAMES];
  int            m_link[FRAMES];
  int            m_pid[FRAMES];
  int            m_vpn[FRAMES];
  logic          a_ok [SLOTS];
  int            a_head[SLOTS];

  always #(CLK_PERIOD/2) clk = ~clk;

  ivt_lookup #(.FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W),
               .HASH_W(HASH_W)) u0 (.*);

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired: act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_hash(input int pid, input int vpn);
    int h = 0;
    for (int b = 0; b < VPN_W; b++) if ((vpn >> b) & 1) h = h ^ (1 << (b % HASH_W));
    for (int b = 0; b < PID_W; b++) if ((pid >> b) & 1) h = h ^ (1 << (b % HASH_W));
    return h;
  endfunction

  task automatic model_clear();
    for (int f = 0; f < FRAMES; f++) begin m_ok[f] = 0; m_lok[f] = 0; m_link[f] = 0; end
    for (int s = 0; s < SLOTS; s++) begin a_ok[s] = 0; a_head[s] = 0; end
  endtask

  task automatic model_insert(input int f, input int pid, input int vpn);
    int h = ref_hash(pid, vpn);
    m_link[f] = a_head[h]; m_lok[f] = a_ok[h];
    m_ok[f] = 1; m_pid[f] = pid; m_vpn[f] = vpn;
    a_head[h] = f; a_ok[h] = 1;
  endtask

  task automatic model_lookup(input int pid, input int vpn,
                              output bit hit, output int frame, output int lat);
    int h = ref_hash(pid, vpn);
    int cur, k;
    hit = 0; frame = 0;
    if (!a_ok[h]) begin lat = 1; return; end
    cur = a_head[h]; k = 0;
    forever begin
      if (m_ok[cur] && m_pid[cur] == pid && m_vpn[cur] == vpn) begin
        hit = 1; frame = cur; lat = k + 2; return;
      end
      if (!m_lok[cur] || k == FRAMES - 1) begin lat = k + 2; return; end
      cur = m_link[cur]; k++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; req_valid = 0; ins_valid = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_clear();
  endtask

  task automatic do_insert(input int f, input int pid, input int vpn);
    @(negedge clk);
    ins_valid = 1; ins_frame = FW'(f); ins_pid = PID_W'(pid); ins_vpn = VPN_W'(vpn);
    while (!ins_ready) @(negedge clk);
    @(posedge clk); #1 ins_valid = 0;
    model_insert(f, pid, vpn);
  endtask

  // issue a lookup and return observed outputs and latency (response left pending)
  task automatic issue(input int pid, input int vpn, input int off,
                       output bit hit, output bit flt, output int frame,
                       output int paddr, output int lat);
    @(negedge clk);
    req_valid = 1; req_pid = PID_W'(pid); req_vpn = VPN_W'(vpn); req_off = OFF_W'(off);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 100);
    hit = rsp_hit; flt = rsp_fault; frame = rsp_frame; paddr = rsp_paddr;
  endtask

  task automatic lookup_check(input int pid, input int vpn, input int off, input string tag);
    bit hit, flt, ehit; int frame, paddr, lat, ef, el;
    model_lookup(pid, vpn, ehit, ef, el);
    issue(pid, vpn, off, hit, flt, frame, paddr, lat);
    check(hit == ehit && flt == !ehit, {tag, " R6 R9 outcome"}, hit, ehit);
    check(lat == el, {tag, " R5 latency"}, lat, el);
    if (ehit) begin
      check(frame == ef, {tag, " R4 frame"}, frame, ef);
      check(paddr == ef * (1 << OFF_W) + off, {tag, " R4 paddr"}, paddr,
            ef * (1 << OFF_W) + off);
    end
  endtask

  initial begin
    bit hit, flt; int frame, paddr, lat;
    do_reset();

    // R1: reset state
    @(negedge clk);
    check(rsp_valid == 0, "R1 rsp_valid after reset", rsp_valid, 0);
    check(req_ready == 1, "R1 req_ready after reset", req_ready, 1);
    check(ins_ready == 1, "R1 ins_ready after reset", ins_ready, 1);
    for (int p = 0; p < 8; p++)
      for (int v = 0; v < 8; v++) begin
        issue(p, v * 7, v, hit, flt, frame, paddr, lat);
        check(flt == 1 && hit == 0, "R1 empty table faults", flt, 1);
        check(lat == 1, "R1 empty latency", lat, 1);
      end

    // R2 R3: fill every frame; keys picked to collide in some slots
    for (int f = 0; f < FRAMES; f++) do_insert(f, (f * 5) % 8, (f * 21 + 3) % 64);

    // R2 R4 R5 R6: exhaustive sweep of every key
    for (int p = 0; p < (1 << PID_W); p++)
      for (int v = 0; v < (1 << VPN_W); v++)
        lookup_check(p, v, (p * 3 + v) % (1 << OFF_W), "sweep");

    // R8: back-pressure holds the response and blocks new requests
    issue(5, (1 * 21 + 3) % 64, 9, hit, flt, frame, paddr, lat);
    rsp_ready = 0;
    req_valid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rsp_valid == 1 && rsp_frame == FW'(frame) && rsp_hit == hit,
            "R8 response held", rsp_frame, frame);
      check(req_ready == 0, "R8 no accept while busy", req_ready, 0);
    end
    req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    check(rsp_valid == 0, "R8 response taken", rsp_valid, 0);

    // R10 R3: insert wins over a simultaneous lookup, lookup sees it
    do_reset();
    @(negedge clk);
    ins_valid = 1; ins_frame = 3; ins_pid = 2; ins_vpn = 40;
    req_valid = 1; req_pid = 2; req_vpn = 40; req_off = 6;
    #1;
    check(req_ready == 0, "R10 lookup held off by insert", req_ready, 0);
    check(ins_ready == 1, "R3 insert accepted", ins_ready, 1);
    @(posedge clk); #1 ins_valid = 0;
    model_insert(3, 2, 40);
    @(negedge clk);
    check(req_ready == 1, "R10 lookup now accepted", req_ready, 1);
    @(posedge clk); #1 req_valid = 0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 100);
    check(rsp_hit == 1 && rsp_frame == 3, "R10 new mapping found", rsp_frame, 3);
    check(lat == 2, "R5 head hit latency", lat, 2);
    @(negedge clk);

    // R3 R5: head insertion order on a single chain
    do_insert(0, 1, 0);
    do_insert(1, 2, 3);
    check(ref_hash(1, 0) == ref_hash(2, 3), "R2 chosen keys collide", ref_hash(2, 3),
          ref_hash(1, 0));
    lookup_check(1, 0, 1, "R3 older entry deeper");
    lookup_check(2, 3, 2, "R3 newest at head");

    // R7: a frame reinserted under the same slot loops on itself
    do_reset();
    do_insert(2, 1, 5);
    do_insert(2, 1, 5);
    for (int v = 0; v < 64; v++)
      if (v != 5 && ref_hash(1, v) == ref_hash(1, 5)) begin
        issue(1, v, 0, hit, flt, frame, paddr, lat);
        check(flt == 1, "R7 looping chain faults", flt, 1);
        check(lat == FRAMES + 1, "R7 bounded visits", lat, FRAMES + 1);
        break;
      end
    lookup_check(1, 5, 11, "R7 loop entry still hits");

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule